// File: doc/BRIEF.md
# Optical Black Level Clamp

This block estimates the dark level of a raw image sensor from a rectangular patch of masked (optical black) pixels and removes that level from the pixel stream. In each frame it sums the pixels that fall inside a window at the top of the frame. The window starts at a programmable column, spans a power-of-two number of columns and covers a power-of-two number of lines. The sum is averaged by a right shift, and the average is multiplied by an unsigned fixed-point gain to give the clamp value. From then on the clamp value is subtracted from every raw pixel. The output is floored at zero.

The estimator is a four-state machine. ST_IDLE waits after reset for the first start of frame. ST_COLLECT accumulates window pixels. ST_LATCH is the one cycle in which the scaled average is written into the clamp register. ST_DONE holds the value until the next frame. Transitions: a valid start-of-frame pixel in any state goes to ST_COLLECT, or straight to ST_LATCH when that same pixel closes the window (a one-by-one window at column 0). In ST_COLLECT, the last window pixel goes to ST_LATCH. ST_LATCH goes to ST_DONE unless a start of frame arrives in that cycle. A start of frame that arrives in ST_COLLECT discards the partial sum and starts a new one.

Top module: `obc_clamp`

## Requirements
- R1: The window width in pixels is 2^`samp_len_sel` for codes 0 to 4 (1, 2, 4, 8 or 16). Codes 5 to 7 select 16.
- R2: The window height is 2^`samp_lines_sel` lines, with the same code map as R1. Line 0 is the line whose first pixel carries `pix_sof`.
- R3: Columns are counted over valid pixels only. Column 0 is the pixel that carries `pix_sol`. The window covers columns `win_start` up to `win_start` + width − 1. Cycles with `pix_valid` low advance no counter.
- R4: The average is the window sum shifted right by log2(width) + log2(height), with the remainder dropped.
- R5: `gain` is unsigned with 4 fractional bits. The clamp value is min(4095, floor(average × gain / 16)).
- R6: `clamp_val` changes two clock edges after the final window pixel is presented, and at no other time. If a new start of frame arrives before the window is complete, the value stays unchanged.
- R7: When `raw_mode` is 1, `out_data` = max(0, `pix_data` − `clamp_val`), using the clamp value held before that pixel's edge.
- R8: When `raw_mode` is 0, `out_data` equals `pix_data` unchanged.
- R9: `out_valid` and `out_data` follow `pix_valid` and `pix_data` with exactly one cycle of latency.
- R10: While `rst_n` is low, `clamp_val`, `out_valid` and `out_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel qualifier |
| pix_sol | input | 1 | Marks the first valid pixel of a line |
| pix_sof | input | 1 | Marks the first valid pixel of a frame (given together with pix_sol) |
| pix_data | input | PIX_W | Raw pixel value |
| raw_mode | input | 1 | 1 applies the clamp, 0 passes pixels through |
| win_start | input | POS_W | First column of the black window |
| samp_len_sel | input | 3 | Window width code |
| samp_lines_sel | input | 3 | Window height code |
| gain | input | GAIN_W | Unsigned gain, 4 fractional bits |
| out_valid | output | 1 | Output pixel qualifier |
| out_data | output | PIX_W | Clamped pixel |
| clamp_val | output | PIX_W | Current clamp value |

## Verification
The bench aims at the exact cycle in which a new clamp takes effect. A design that latches early, or one that applies the new value a cycle late, would give wrong values on the pixels that directly follow the window. It also drives a one-by-one window on the start-of-frame pixel, a width code above 4 and a window that ends on the last column. A design that mishandles any of these would sum the wrong set of pixels or never complete the window. Further cases are a gain large enough to overflow the pixel width and black levels above the active pixels. A design that failed to saturate there would wrap to small values. The last case is a frame cut short before its window completes: a design that latched the partial sum would change `clamp_val`.

// File: rtl/obc_pkg.sv
`timescale 1ns/1ps
package obc_pkg;
    localparam int SEL_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_LATCH,
        ST_DONE
    } est_state_t;

    // code to log2 of a window dimension; codes above 4 select the largest size
    function automatic logic [SEL_W-1:0] sel_to_log2(input logic [SEL_W-1:0] sel);
        return (sel > 3'd4) ? 3'd4 : sel;
    endfunction
endpackage

// File: rtl/obc_window_track.sv
`timescale 1ns/1ps
module obc_window_track
    import obc_pkg::*;
#(
    parameter int POS_W    = 12,
    parameter int MAX_LOG2 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic             pix_sol,
    input  logic             pix_sof,
    input  logic [POS_W-1:0] win_start,
    input  logic [SEL_W-1:0] len_log2,
    input  logic [SEL_W-1:0] lines_log2,
    output logic             in_win,
    output logic             win_last
);
    localparam int LINE_W = MAX_LOG2 + 1;

    logic [POS_W-1:0]  col_nxt_q;
    logic [POS_W-1:0]  col_cur;
    logic [LINE_W-1:0] line_q;
    logic [LINE_W-1:0] line_cur;
    logic [POS_W:0]    win_end;
    logic [LINE_W:0]   n_lines;
    logic              in_col;
    logic              in_line;

    always_comb begin
        col_cur = pix_sol ? '0 : col_nxt_q;
        if (pix_sof)
            line_cur = '0;
        else if (pix_sol && (line_q != '1))
            line_cur = line_q + 1'b1;
        else
            line_cur = line_q;
        win_end  = {1'b0, win_start} + ((POS_W+1)'(1) << len_log2);
        n_lines  = (LINE_W+1)'(1) << lines_log2;
        in_col   = ({1'b0, col_cur} >= {1'b0, win_start}) && ({1'b0, col_cur} < win_end);
        in_line  = {1'b0, line_cur} < n_lines;
        in_win   = pix_valid && in_col && in_line;
        win_last = in_win && (({1'b0, col_cur} + 1'b1) == win_end)
                          && (({1'b0, line_cur} + 1'b1) == n_lines);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_nxt_q <= '0;
            line_q    <= '0;
        end else if (pix_valid) begin
            col_nxt_q <= (col_cur == '1) ? col_cur : col_cur + 1'b1;
            line_q    <= line_cur;
        end
    end
endmodule

// File: rtl/obc_estimator.sv
`timescale 1ns/1ps
module obc_estimator
    import obc_pkg::*;
#(
    parameter int PIX_W     = 12,
    parameter int GAIN_W    = 8,
    parameter int GAIN_FRAC = 4,
    parameter int MAX_LOG2  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic              pix_sof,
    input  logic [PIX_W-1:0]  pix_data,
    input  logic              in_win,
    input  logic              win_last,
    input  logic [SEL_W:0]    shift_total,
    input  logic [GAIN_W-1:0] gain,
    output logic [PIX_W-1:0]  clamp_val,
    output est_state_t        state
);
    localparam int ACC_W  = PIX_W + 2 * MAX_LOG2;
    localparam int PROD_W = PIX_W + GAIN_W;

    est_state_t        state_nxt;
    logic              sof_v;
    logic              collecting;
    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  acc_base;
    logic [ACC_W-1:0]  avg_full;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;
    logic [PIX_W-1:0]  scaled_sat;

    always_comb begin
        sof_v     = pix_valid && pix_sof;
        state_nxt = state;
        if (sof_v) begin
            state_nxt = win_last ? ST_LATCH : ST_COLLECT;
        end else begin
            unique case (state)
                ST_IDLE:    state_nxt = ST_IDLE;
                ST_COLLECT: state_nxt = win_last ? ST_LATCH : ST_COLLECT;
                ST_LATCH:   state_nxt = ST_DONE;
                ST_DONE:    state_nxt = ST_DONE;
                default:    state_nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // average by shift, gain multiply, saturation to pixel width
    always_comb begin
        collecting = sof_v || (state == ST_COLLECT);
        acc_base   = sof_v ? '0 : acc_q;
        avg_full   = acc_q >> shift_total;
        prod       = PROD_W'(avg_full[PIX_W-1:0]) * PROD_W'(gain);
        scaled     = prod >> GAIN_FRAC;
        scaled_sat = (|scaled[PROD_W-1:PIX_W]) ? '1 : scaled[PIX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q     <= '0;
            clamp_val <= '0;
        end else begin
            if (collecting)
                acc_q <= acc_base + (in_win ? ACC_W'(pix_data) : '0);
            if (state == ST_LATCH)
                clamp_val <= scaled_sat;
        end
    end
endmodule

// File: rtl/obc_output_stage.sv
`timescale 1ns/1ps
module obc_output_stage #(
    parameter int PIX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             raw_mode,
    input  logic [PIX_W-1:0] clamp_val,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_data
);
    logic [PIX_W:0]   diff;
    logic [PIX_W-1:0] res;

    always_comb begin
        diff = {1'b0, pix_data} - {1'b0, clamp_val};
        if (!raw_mode)
            res = pix_data;
        else if (diff[PIX_W])
            res = '0;
        else
            res = diff[PIX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= pix_valid;
            out_data  <= res;
        end
    end
endmodule

// File: rtl/obc_clamp.sv
`timescale 1ns/1ps
module obc_clamp
    import obc_pkg::*;
#(
    parameter int PIX_W     = 12,
    parameter int POS_W     = 12,
    parameter int GAIN_W    = 8,
    parameter int GAIN_FRAC = 4,
    parameter int MAX_LOG2  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic              pix_sol,
    input  logic              pix_sof,
    input  logic [PIX_W-1:0]  pix_data,
    input  logic              raw_mode,
    input  logic [POS_W-1:0]  win_start,
    input  logic [2:0]        samp_len_sel,
    input  logic [2:0]        samp_lines_sel,
    input  logic [GAIN_W-1:0] gain,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_data,
    output logic [PIX_W-1:0]  clamp_val
);
    logic [SEL_W-1:0] len_log2;
    logic [SEL_W-1:0] lines_log2;
    logic [SEL_W:0]   shift_total;
    logic             in_win;
    logic             win_last;
    est_state_t       est_state;

    always_comb begin
        len_log2    = sel_to_log2(samp_len_sel);
        lines_log2  = sel_to_log2(samp_lines_sel);
        shift_total = {1'b0, len_log2} + {1'b0, lines_log2};
    end

    obc_window_track #(.POS_W(POS_W), .MAX_LOG2(MAX_LOG2)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_valid  (pix_valid),
        .pix_sol    (pix_sol),
        .pix_sof    (pix_sof),
        .win_start  (win_start),
        .len_log2   (len_log2),
        .lines_log2 (lines_log2),
        .in_win     (in_win),
        .win_last   (win_last)
    );

    obc_estimator #(
        .PIX_W(PIX_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .MAX_LOG2(MAX_LOG2)
    ) u_est (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_valid   (pix_valid),
        .pix_sof     (pix_sof),
        .pix_data    (pix_data),
        .in_win      (in_win),
        .win_last    (win_last),
        .shift_total (shift_total),
        .gain        (gain),
        .clamp_val   (clamp_val),
        .state       (est_state)
    );

    obc_output_stage #(.PIX_W(PIX_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_valid (pix_valid),
        .pix_data  (pix_data),
        .raw_mode  (raw_mode),
        .clamp_val (clamp_val),
        .out_valid (out_valid),
        .out_data  (out_data)
    );
endmodule

// File: rtl/obc_clamp_chk.sv
`timescale 1ns/1ps
module obc_clamp_chk
    import obc_pkg::*;
#(
    parameter int PIX_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_valid,
    input logic [PIX_W-1:0] pix_data,
    input logic             raw_mode,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_data,
    input logic [PIX_W-1:0] clamp_val,
    input est_state_t       est_state
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid); // R9
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid); // R9
    AST_BYPASS_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !raw_mode) |=> (out_data == $past(pix_data))); // R8
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && raw_mode) |=> (out_data <= $past(pix_data))); // R7
    AST_FLOOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && raw_mode && (pix_data <= clamp_val)) |=> (out_data == '0)); // R7
    AST_CLAMP_LATCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (clamp_val != $past(clamp_val)) |-> ($past(est_state) == ST_LATCH)); // R6
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (clamp_val == '0 && !out_valid && out_data == '0)); // R10
endmodule

bind obc_clamp obc_clamp_chk #(.PIX_W(PIX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .pix_data  (pix_data),
    .raw_mode  (raw_mode),
    .out_valid (out_valid),
    .out_data  (out_data),
    .clamp_val (clamp_val),
    .est_state (est_state)
);

// File: tb/test_obc_clamp.sv
`timescale 1ns/1ps
module test_obc_clamp;
    localparam int PIX_W  = 12;
    localparam int LINE_N = 24;
    localparam int FRAME_LINES = 18;
    localparam int NV = 8;
    // len_sel, lines_sel, win_start, gain, seed, raw, expected clamp
    localparam int TBL [NV][7] = '{
        '{0, 0, 0,  16,  100, 1, 100},   // R1 R2 1x1 window on the frame-start pixel
        '{2, 1, 3,  16,  200, 1, 217},   // R3 R4 4x2 window at column 3
        '{4, 4, 8,  24,  300, 1, 598},   // R5 16x16 ending on last column, gain 1.5
        '{3, 2, 5,   8,   50, 1, 43},    // R5 gain 0.5
        '{7, 3, 2,  32,  400, 1, 906},   // R1 code 7 acts as 16
        '{1, 0, 0, 255, 3900, 1, 4095},  // R5 saturation, R7 floor at zero
        '{2, 2, 1,  16,   10, 0, 28},    // R8 bypass mode
        '{0, 0, 20,  0,    0, 1, 0}      // R5 zero gain
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pix_valid = 1'b0;
    logic             pix_sol = 1'b0;
    logic             pix_sof = 1'b0;
    logic [PIX_W-1:0] pix_data = '0;
    logic             raw_mode = 1'b1;
    logic [11:0]      win_start = '0;
    logic [2:0]       samp_len_sel = '0;
    logic [2:0]       samp_lines_sel = '0;
    logic [7:0]       gain = '0;
    logic             out_valid;
    logic [PIX_W-1:0] out_data;
    logic [PIX_W-1:0] clamp_val;

    int n_run = 0;
    int n_fail = 0;
    int cur_clamp = 0;
    int next_clamp = 0;
    int pend = 0;
    bit done = 1'b0;

    obc_clamp i_obc_clamp (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sol(pix_sol),
        .pix_sof(pix_sof), .pix_data(pix_data), .raw_mode(raw_mode),
        .win_start(win_start), .samp_len_sel(samp_len_sel),
        .samp_lines_sel(samp_lines_sel), .gain(gain),
        .out_valid(out_valid), .out_data(out_data), .clamp_val(clamp_val)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input bit v, input bit sol, input bit sof, input int d, input bit last);
        int exp_o;
        @(negedge clk);
        pix_valid = v;
        pix_sol   = sol;
        pix_sof   = sof;
        pix_data  = PIX_W'(d);
        if (!raw_mode) exp_o = d;
        else           exp_o = (d > cur_clamp) ? d - cur_clamp : 0;
        @(posedge clk);
        #1;
        check(out_valid == v, "R9 out_valid", int'(out_valid), int'(v));
        if (v) begin
            if (raw_mode) check(int'(out_data) == exp_o, "R7 clamped pixel", int'(out_data), exp_o);
            else          check(int'(out_data) == exp_o, "R8 bypass pixel", int'(out_data), exp_o);
        end
        if (pend > 0) begin
            pend--;
            if (pend == 0) cur_clamp = next_clamp;
        end
        if (last) pend = 1;
        check(int'(clamp_val) == cur_clamp, "R6 clamp timing", int'(clamp_val), cur_clamp);
    endtask

    task automatic run_frame(input int ls, input int ns, input int st, input int g,
                             input int seed, input int rawm, input int nl, input int expc);
        int wl;
        int wn;
        wl = (ls > 4) ? 16 : (1 << ls);
        wn = (ns > 4) ? 16 : (1 << ns);
        @(negedge clk);
        samp_len_sel   = 3'(ls);
        samp_lines_sel = 3'(ns);
        win_start      = 12'(st);
        gain           = 8'(g);
        raw_mode       = rawm[0];
        next_clamp     = expc;
        for (int l = 0; l < nl; l++) begin
            for (int c = 0; c < LINE_N; c++) begin
                tick(1'b1, c == 0, (l == 0) && (c == 0), (seed + l * 7 + c * 3) & 4095,
                     (l == wn - 1) && (c == st + wl - 1));
                if ((c % 5) == 4) tick(1'b0, 1'b0, 1'b0, 0, 1'b0);  // R3 gaps
            end
        end
        tick(1'b0, 1'b0, 1'b0, 0, 1'b0);
        tick(1'b0, 1'b0, 1'b0, 0, 1'b0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(clamp_val == '0, "R10 reset clamp", int'(clamp_val), 0);
        check(out_valid == 1'b0, "R10 reset valid", int'(out_valid), 0);
        check(out_data == '0, "R10 reset data", int'(out_data), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_frame(TBL[i][0], TBL[i][1], TBL[i][2], TBL[i][3], TBL[i][4],
                      TBL[i][5], FRAME_LINES, TBL[i][6]);
            check(int'(clamp_val) == TBL[i][6], "R1 R2 R3 R4 R5 clamp value",
                  int'(clamp_val), TBL[i][6]);
        end

        // R6: frame cut short before the 2-line window completes
        run_frame(2, 1, 3, 16, 200, 1, 1, 217);
        check(int'(clamp_val) == 0, "R6 aborted window keeps clamp", int'(clamp_val), 0);
        run_frame(2, 1, 3, 16, 200, 1, FRAME_LINES, 217);
        check(int'(clamp_val) == 217, "R6 window after abort", int'(clamp_val), 217);

        // R10: reset mid-stream
        @(negedge clk);
        pix_valid = 1'b1;
        pix_data  = 12'd900;
        rst_n     = 1'b0;
        #1;
        check(clamp_val == '0, "R10 reset clears clamp", int'(clamp_val), 0);
        check(out_valid == 1'b0, "R10 reset clears valid", int'(out_valid), 0);
        @(posedge clk);
        #1;
        check(out_data == '0, "R10 reset holds data", int'(out_data), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule